// File: doc/BRIEF.md
# Rotating Drum Sector Position Tracker

This block follows the angular position of a rotating drum whose tracks are divided into 32 sectors. A prescaler divides the system clock down to one tick per sector period (521 microseconds at 3600 RPM). A free-running sector counter advances on every tick, whatever commands are in flight. From that position, a track register and a core-compare bit supplied from outside, the block assembles a 16-bit sector address status word.

While a transfer is active, its own sector number replaces the free-running position in the status word, so the reported sector can jump. The rotation counter keeps turning underneath, and its value shows again once the transfer ends. A compare flag is high exactly while the reported sector equals the target sector taken from the loaded initial sector address. The track register captures the track number of each new request. Both reset and a controller-clear zero the sector and track values and restart the prescaler.

Top module: `drum_sector_tracker`

## Requirements
- R1: After reset the sector field and the track field read 0, and the prescaler starts from the beginning of a sector period.
- R2: With no transfer active, the sector field advances by exactly one every TICK_DIV clock cycles and holds its value between those advances.
- R3: The sector field wraps from 31 to 0, so it counts modulo 32.
- R4: The status word holds the reported sector in bits 4:0, the track register in bits 14:5 and the core compare input in bit 15.
- R5: A clock edge with trk_load high loads trk_in into the track register. Without trk_load the track register holds its value.
- R6: While xfer_active is high, bits 4:0 of the status word show xfer_sector. The free-running count goes on advancing meanwhile, and it shows again as soon as xfer_active drops.
- R7: sec_match is high if and only if the reported sector equals target_sec.
- R8: A clock edge with clr high zeroes the sector count and the track register and restarts the prescaler. It takes precedence over trk_load and over a sector tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous controller-clear |
| target_sec | input | 5 | Sector field of the loaded initial sector address |
| trk_load | input | 1 | Capture trk_in into the track register |
| trk_in | input | 10 | Track number of the current request |
| core_cmp | input | 1 | Core address compare bit to report |
| xfer_active | input | 1 | A transfer is in progress |
| xfer_sector | input | 5 | Sector used by the active transfer |
| sas_word | output | 16 | Sector address status word |
| sec_match | output | 1 | Reported sector equals target sector |

## Verification
Three events can land on the same clock edge: a prescaler tick, a controller-clear and a track load. The stimulus places clr and trk_load both on tick edges and off them. A bench-side reference model tracks the rotation count and the track register, and the outputs are compared with it on every cycle. This shows whether clear beats both the tick and the load, and whether a load on a tick edge still lands. Transfer windows that open and close around a tick show whether the hidden count kept advancing during the override.

// File: rtl/drum_pos_pkg.sv
package drum_pos_pkg;
   localparam int SECTOR_PERIOD_NS = 521000;
   localparam int DEF_SEC_W        = 5;
   localparam int DEF_TRK_W        = 10;

   function automatic int cycles_per_sector(input int clk_mhz);
      return (SECTOR_PERIOD_NS / 1000) * clk_mhz;
   endfunction
endpackage

// File: rtl/drum_tick_gen.sv
module drum_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 1) $error("drum_tick_gen: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divider
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt_q <= '0;
            else if (restart)                      cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))        cnt_q <= '0;
            else                                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/drum_wrap_ctr.sv
module drum_wrap_ctr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] value
);
   initial begin
      if (W < 1) $error("drum_wrap_ctr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (clr)  value <= '0;
      else if (step) value <= value + 1'b1;
   end
endmodule

// File: rtl/drum_track_reg.sv
module drum_track_reg #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/drum_sector_tracker.sv
module drum_sector_tracker
   import drum_pos_pkg::*;
#(
   parameter int SEC_W    = DEF_SEC_W,
   parameter int TRK_W    = DEF_TRK_W,
   parameter int CLK_MHZ  = 50,
   parameter int TICK_DIV = cycles_per_sector(CLK_MHZ)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic [SEC_W-1:0]       target_sec,
   input  logic                   trk_load,
   input  logic [TRK_W-1:0]       trk_in,
   input  logic                   core_cmp,
   input  logic                   xfer_active,
   input  logic [SEC_W-1:0]       xfer_sector,
   output logic [SEC_W+TRK_W:0]   sas_word,
   output logic                   sec_match
);
   localparam int STAT_W = SEC_W + TRK_W + 1;

   initial begin
      if (SEC_W < 1 || TRK_W < 1) $error("drum_sector_tracker: field widths must be positive");
      if (TICK_DIV < 1)           $error("drum_sector_tracker: TICK_DIV must be positive");
      if (STAT_W != 16)           $warning("drum_sector_tracker: status word is not 16 bits wide");
   end

   logic             tick;
   logic [SEC_W-1:0] rot_sec;
   logic [TRK_W-1:0] trk_q;
   logic [SEC_W-1:0] shown_sec;

   drum_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clr),
      .tick    (tick)
   );

   drum_wrap_ctr #(.W(SEC_W)) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (tick),
      .value (rot_sec)
   );

   drum_track_reg #(.W(TRK_W)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load  (trk_load),
      .din   (trk_in),
      .q     (trk_q)
   );

   assign shown_sec = xfer_active ? xfer_sector : rot_sec;
   assign sas_word  = {core_cmp, trk_q, shown_sec};
   assign sec_match = (shown_sec == target_sec);
endmodule

// File: rtl/drum_sector_tracker_chk.sv
module drum_sector_tracker_chk #(
   parameter int SEC_W = 5,
   parameter int TRK_W = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic [SEC_W-1:0]     target_sec,
   input logic                 trk_load,
   input logic [TRK_W-1:0]     trk_in,
   input logic                 core_cmp,
   input logic                 xfer_active,
   input logic [SEC_W-1:0]     xfer_sector,
   input logic [SEC_W+TRK_W:0] sas_word
 , input logic                 sec_match
);
   wire [SEC_W-1:0] f_sec = sas_word[SEC_W-1:0];
   wire [TRK_W-1:0] f_trk = sas_word[SEC_W+TRK_W-1:SEC_W];

   // R8
   clr_zero_trk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> f_trk == '0);
   // R8
   clr_zero_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !xfer_active ##1 !xfer_active |-> f_sec == '0);
   // R5
   trk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trk_load && !clr |=> f_trk == $past(trk_in));
   // R5
   trk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trk_load && !clr |=> $stable(f_trk));
   // R6
   xfer_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_active |-> f_sec == xfer_sector);
   // R4
   cmp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sas_word[SEC_W+TRK_W] == core_cmp);
   // R7
   match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_match == (f_sec == target_sec));
   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active && !clr ##1 !xfer_active |->
         (f_sec == $past(f_sec)) || (f_sec == $past(f_sec) + 1'b1));
endmodule

bind drum_sector_tracker drum_sector_tracker_chk #(.SEC_W(SEC_W), .TRK_W(TRK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .target_sec(target_sec),
   .trk_load(trk_load), .trk_in(trk_in), .core_cmp(core_cmp),
   .xfer_active(xfer_active), .xfer_sector(xfer_sector),
   .sas_word(sas_word), .sec_match(sec_match)
);

// File: tb/drum_sector_tracker_bench.sv
module drum_sector_tracker_bench;
   localparam int DIV   = 5;
   localparam int NSEC  = 32;
   localparam int LIMIT = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic [4:0] target_sec = '0;
   logic       trk_load = 1'b0;
   logic [9:0] trk_in = '0;
   logic       core_cmp = 1'b0;
   logic       xfer_active = 1'b0;
   logic [4:0] xfer_sector = '0;
   logic [15:0] sas_word;
   logic       sec_match;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   int m_pc = 0;
   int m_sec = 0;
   int m_trk = 0;

   always #10 clk = ~clk;

   drum_sector_tracker #(.TICK_DIV(DIV)) u_drum_sector_tracker (
      .clk(clk), .rst_n(rst_n), .clr(clr), .target_sec(target_sec),
      .trk_load(trk_load), .trk_in(trk_in), .core_cmp(core_cmp),
      .xfer_active(xfer_active), .xfer_sector(xfer_sector),
      .sas_word(sas_word), .sec_match(sec_match)
   );

   // reference model: rotation position and track register
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         m_pc  <= 0;
         m_sec <= 0;
         m_trk <= 0;
      end else begin
         if (m_pc == DIV - 1) begin
            m_pc  <= 0;
            m_sec <= (m_sec + 1) % NSEC;
         end else begin
            m_pc <= m_pc + 1;
         end
         if (trk_load) m_trk <= int'(trk_in);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_sec;
         exp_sec = xfer_active ? int'(xfer_sector) : m_sec;
         check(xfer_active ? "R6 sector override" : "R2 R3 sector field",
               int'(sas_word[4:0]), exp_sec);
         check("R5 track field", int'(sas_word[14:5]), m_trk);
         check("R4 compare bit", int'(sas_word[15]), int'(core_cmp));
         check("R7 sec_match", int'(sec_match), int'(exp_sec == int'(target_sec)));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, LIMIT);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   initial begin
      step(3);
      // R1: reset state seen while reset is held
      @(negedge clk);
      check("R1 reset sector", int'(sas_word[4:0]), 0);
      check("R1 reset track", int'(sas_word[14:5]), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R1: first advance exactly DIV edges after release
      step(DIV - 1);
      @(negedge clk);
      check("R1 prescaler restart (before)", int'(sas_word[4:0]), 0);
      @(posedge clk); #1;
      @(negedge clk);
      check("R1 prescaler restart (after)", int'(sas_word[4:0]), 1);
      @(posedge clk); #1;

      // free run through a wrap (R3)
      target_sec = 5'd7;
      step(DIV * NSEC + 3);

      // track loads, some on tick edges (R5)
      for (int k = 0; k < 12; k++) begin
         trk_in   = 10'(k * 83 + 1);
         trk_load = 1'b1;
         core_cmp = k[0];
         step(1);
         trk_load = 1'b0;
         step(k % DIV + 1);
      end

      // transfer override windows spanning ticks (R6)
      for (int k = 0; k < 6; k++) begin
         xfer_sector = 5'(k * 11 + 3);
         target_sec  = (k % 2 == 0) ? xfer_sector : 5'(k);
         xfer_active = 1'b1;
         step(DIV * 2 + k);
         xfer_active = 1'b0;
         step(3);
      end

      // controller clear at every prescaler phase, together with load (R8)
      for (int k = 0; k < 2 * DIV; k++) begin
         step(k + 2);
         trk_in   = 10'(700 + k);
         trk_load = (k % 2 == 0);
         clr      = 1'b1;
         step(1);
         clr      = 1'b0;
         trk_load = 1'b0;
      end

      // R3: exactly one revolution after a clear returns to sector 0
      clr = 1'b1;
      step(1);
      clr = 1'b0;
      step(DIV * NSEC);
      @(negedge clk);
      check("R3 full revolution", int'(sas_word[4:0]), 0);
      @(posedge clk); #1;

      // randomised mix
      for (int k = 0; k < 400; k++) begin
         clr         = ($urandom_range(0, 40) == 0);
         trk_load    = ($urandom_range(0, 5) == 0);
         trk_in      = 10'($urandom);
         core_cmp    = 1'($urandom);
         xfer_active = ($urandom_range(0, 3) == 0);
         xfer_sector = 5'($urandom);
         target_sec  = 5'($urandom_range(0, 3) == 0 ? m_sec : $urandom);
         step(1);
      end
      clr = 1'b0; trk_load = 1'b0; xfer_active = 1'b0;
      step(DIV * 3);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule